// File: doc/BRIEF.md
# Prioritised 64-Source Interrupt Controller

This block collects 64 level-sensitive interrupt requests, keeps an enable bit and a 4-bit priority for each, and picks one winner among the requests that are active, enabled and carry a non-zero priority. It presents the winner's level and a 12-bit vector code to the processor, and raises the processor interrupt only when that level is strictly above a 4-bit mask level supplied by the processor.

Software reaches the block over a simple register bus: a write strobe, a read strobe, a byte address and 32-bit data, with every register on an 8-byte boundary. Enables are changed through separate set and clear addresses, so no read-modify-write is needed. A control bit picks how the four external request lines are used. With the bit set, each line is its own source (sources 0 to 3). With the bit cleared, the four lines together form one encoded level, and sources 0 to 3 are not used.

Arbitration is combinational from the register state and the inputs. The three processor-facing outputs are registered, so they follow their inputs by one clock.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the control bit is 0, every enable bit is 0, every priority is 0, and cpu_irq, cpu_level and cpu_vector are 0.
- R2: Enables are set by writing ones at 0x70 (sources 0-31) or 0x78 (sources 32-63). They are cleared by writing ones at 0x80 or 0x88. Zero bits in such a write leave the enable unchanged. A read at either the enable or the disable address returns the current enable word.
- R3: Priorities live in eight registers at 0x10 + 8*k. Source i uses register i/8, bits [4*(i%8)+3 : 4*(i%8)]. A read returns what was written.
- R4: Control bit 0 is the line mode bit. Writing a 1 in bit 0 at 0x00 sets it, and writing a 1 in bit 0 at 0x08 clears it. A 0 in bit 0 has no effect. A read at either address returns the bit in bit 0.
- R5: A read at 0x50/0x58 returns the raw source inputs, and a read at 0x60/0x68 returns those inputs ANDed with the enable mask. Sources 0-3 are the external lines, and they read 0 in encoded mode.
- R6: A source whose priority is 0 never wins arbitration.
- R7: Among eligible sources, the highest priority wins. On equal priority, the lowest source number wins.
- R8: The vector code is the source's ordinal times 0x20. Source i<4 has ordinal 0x12+3*i, and source i>=4 has ordinal 0x3C+i. When nothing is eligible, cpu_level and cpu_vector are 0.
- R9: cpu_irq is 1 only when a winner exists and its level is strictly greater than cpu_mask.
- R10: In encoded mode, a non-zero value L on the four lines competes at level L with vector 0x240. It needs no enable bit, and it wins ties against all sources.
- R11: cpu_irq, cpu_level and cpu_vector are registered. A change at the inputs or in the register state appears at these outputs one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address, 8-byte aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| irl_in | input | 4 | External request lines or encoded level |
| periph_irq | input | 60 | Level requests for sources 4 to 63 |
| cpu_mask | input | 4 | Processor's current mask level |
| cpu_irq | output | 1 | Interrupt request to the processor |
| cpu_level | output | 4 | Level of the current winner |
| cpu_vector | output | 12 | Vector code of the current winner |

## Verification
The assertions check four rules on every cycle. The enable words take on the set and clear writes the cycle after they happen, and they hold steady when no write occurs. The mode bit follows its own set and clear addresses. The processor interrupt never fires at a level at or below the mask. Only the bench scenarios can show which source wins: the priority order, the lowest-number tie rule, the vector codes, the encoded-level mode, and the one-cycle output latency. Each of these depends on a particular mix of inputs and programmed priorities.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned NUM_SRC   = 64;
  localparam int unsigned PRIO_W    = 4;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned VEC_W     = 12;
  localparam int unsigned IRL_LINES = 4;
  localparam int unsigned IDX_W     = $clog2(NUM_SRC);

  // Fixed vector code of the encoded external level (ordinal 0x12).
  localparam logic [VEC_W-1:0] ENC_VECTOR = 12'h240;

  // Vector code: ordinal shifted left by five.
  function automatic logic [VEC_W-1:0] src_vector(input int unsigned idx);
    logic [6:0] ord;
    if (idx < IRL_LINES) ord = 7'(32'h12 + 3 * idx);
    else                 ord = 7'(32'h3C + idx);
    return {ord, 5'b0};
  endfunction
endpackage

// File: rtl/irq_src_mux.sv
module irq_src_mux
  import irq_prio_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC,
  parameter int unsigned N_IRL = IRL_LINES
) (
  input  logic               line_mode,
  input  logic [N_IRL-1:0]   irl_in,
  input  logic [N_SRC-N_IRL-1:0] periph_irq,
  output logic [N_SRC-1:0]   raw_src,
  output logic [N_IRL-1:0]   enc_level
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    if (g < N_IRL) begin : g_line
      assign raw_src[g] = line_mode & irl_in[g];
    end else begin : g_per
      assign raw_src[g] = periph_irq[g-N_IRL];
    end
  end

  assign enc_level = line_mode ? '0 : irl_in;
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import irq_prio_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC,
  parameter int unsigned PW    = PRIO_W,
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned DW    = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [N_SRC-1:0] raw_src,
  output logic             line_mode,
  output logic [N_SRC-1:0] en_mask,
  output logic [N_SRC*PW-1:0] prio_flat
);
  localparam int unsigned WORDS     = N_SRC / DW;
  localparam int unsigned PER_REG   = DW / PW;
  localparam int unsigned PRIO_REGS = N_SRC / PER_REG;
  localparam int unsigned WI_W      = AW - 3;
  localparam int unsigned W_CSET    = 0;
  localparam int unsigned W_CCLR    = 1;
  localparam int unsigned W_PRIO    = 2;
  localparam int unsigned W_STAT    = 10;
  localparam int unsigned W_REQ     = 12;
  localparam int unsigned W_EN      = 14;
  localparam int unsigned W_DIS     = 16;

  logic [WI_W-1:0]     wi;
  logic                aligned;
  logic                wr_hit;
  logic                mode_q, mode_d;
  logic [N_SRC-1:0]    en_q, en_d;
  logic [N_SRC*PW-1:0] prio_q, prio_d;

  assign wi      = bus_addr[AW-1:3];
  assign aligned = (bus_addr[2:0] == 3'b000);
  assign wr_hit  = bus_wr & aligned;

  always_comb begin
    mode_d = mode_q;
    en_d   = en_q;
    prio_d = prio_q;
    if (wi == WI_W'(W_CSET) && bus_wdata[0]) mode_d = 1'b1;
    if (wi == WI_W'(W_CCLR) && bus_wdata[0]) mode_d = 1'b0;
    for (int w = 0; w < WORDS; w++) begin
      if (wi == WI_W'(W_EN + w))  en_d[w*DW +: DW] = en_q[w*DW +: DW] | bus_wdata;
      if (wi == WI_W'(W_DIS + w)) en_d[w*DW +: DW] = en_q[w*DW +: DW] & ~bus_wdata;
    end
    for (int k = 0; k < PRIO_REGS; k++) begin
      if (wi == WI_W'(W_PRIO + k)) prio_d[k*DW +: DW] = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      en_q   <= '0;
      prio_q <= '0;
    end else if (wr_hit) begin
      mode_q <= mode_d;
      en_q   <= en_d;
      prio_q <= prio_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && aligned) begin
      if (wi == WI_W'(W_CSET) || wi == WI_W'(W_CCLR)) bus_rdata = {{(DW-1){1'b0}}, mode_q};
      for (int k = 0; k < PRIO_REGS; k++) begin
        if (wi == WI_W'(W_PRIO + k)) bus_rdata = prio_q[k*DW +: DW];
      end
      for (int w = 0; w < WORDS; w++) begin
        if (wi == WI_W'(W_STAT + w)) bus_rdata = raw_src[w*DW +: DW];
        if (wi == WI_W'(W_REQ + w))  bus_rdata = raw_src[w*DW +: DW] & en_q[w*DW +: DW];
        if (wi == WI_W'(W_EN + w) || wi == WI_W'(W_DIS + w)) bus_rdata = en_q[w*DW +: DW];
      end
    end
  end

  assign line_mode = mode_q;
  assign en_mask   = en_q;
  assign prio_flat = prio_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC,
  parameter int unsigned PW    = PRIO_W,
  parameter int unsigned VW    = VEC_W,
  parameter int unsigned XW    = IDX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_SRC-1:0]    raw_src,
  input  logic [N_SRC-1:0]    en_mask,
  input  logic [N_SRC*PW-1:0] prio_flat,
  input  logic [PW-1:0]       enc_level,
  input  logic [PW-1:0]       cpu_mask,
  output logic                cpu_irq,
  output logic [PW-1:0]       cpu_level,
  output logic [VW-1:0]       cpu_vector
);
  logic [N_SRC-1:0] elig;
  logic [PW-1:0]    best_lvl;
  logic [XW-1:0]    best_idx;
  logic             best_hit;
  logic             enc_win;
  logic             irq_d;
  logic [PW-1:0]    lvl_d;
  logic [VW-1:0]    vec_d;

  for (genvar g = 0; g < N_SRC; g++) begin : g_elig
    assign elig[g] = raw_src[g] & en_mask[g] & (prio_flat[g*PW +: PW] != '0);
  end

  // Scan from the top so that ">=" leaves the lowest index on ties.
  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    best_hit = 1'b0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i] && prio_flat[i*PW +: PW] >= best_lvl) begin
        best_lvl = prio_flat[i*PW +: PW];
        best_idx = XW'(i);
        best_hit = 1'b1;
      end
    end
    enc_win = (enc_level != '0) && (enc_level >= best_lvl);
  end

  always_comb begin
    lvl_d = '0;
    vec_d = '0;
    if (enc_win) begin
      lvl_d = enc_level;
      vec_d = ENC_VECTOR;
    end else if (best_hit) begin
      lvl_d = best_lvl;
      vec_d = src_vector(32'(best_idx));
    end
    irq_d = (enc_win || best_hit) && (lvl_d > cpu_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_irq    <= 1'b0;
      cpu_level  <= '0;
      cpu_vector <= '0;
    end else begin
      cpu_irq    <= irq_d;
      cpu_level  <= lvl_d;
      cpu_vector <= vec_d;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [IRL_LINES-1:0]       irl_in,
  input  logic [NUM_SRC-IRL_LINES-1:0] periph_irq,
  input  logic [PRIO_W-1:0]          cpu_mask,
  output logic                       cpu_irq,
  output logic [PRIO_W-1:0]          cpu_level,
  output logic [VEC_W-1:0]           cpu_vector
);
  logic [1:0]                rst_sync;
  logic                      rst_sync_n;
  logic                      line_mode;
  logic [NUM_SRC-1:0]        raw_src;
  logic [NUM_SRC-1:0]        en_mask;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [IRL_LINES-1:0]      enc_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  irq_src_mux i_src_mux (
    .line_mode (line_mode),
    .irl_in    (irl_in),
    .periph_irq(periph_irq),
    .raw_src   (raw_src),
    .enc_level (enc_level)
  );

  irq_reg_file i_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .raw_src  (raw_src),
    .line_mode(line_mode),
    .en_mask  (en_mask),
    .prio_flat(prio_flat)
  );

  irq_arbiter i_arb (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .raw_src   (raw_src),
    .en_mask   (en_mask),
    .prio_flat (prio_flat),
    .enc_level (enc_level),
    .cpu_mask  (cpu_mask),
    .cpu_irq   (cpu_irq),
    .cpu_level (cpu_level),
    .cpu_vector(cpu_vector)
  );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_prio_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [PRIO_W-1:0]  cpu_mask,
  input logic               cpu_irq,
  input logic [PRIO_W-1:0]  cpu_level,
  input logic [VEC_W-1:0]   cpu_vector,
  input logic               line_mode,
  input logic [NUM_SRC-1:0] en_mask
);
  p_enable_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h70) |=> ((en_mask[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

  p_disable_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h80) |=> ((en_mask[31:0] & $past(bus_wdata)) == '0));

  p_enable_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(en_mask));

  p_mode_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h00 && bus_wdata[0]) |=> line_mode);

  p_mode_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h08 && bus_wdata[0]) |=> !line_mode);

  p_irq_above_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (cpu_level > $past(cpu_mask)));

  p_idle_outputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_level == '0) |-> (!cpu_irq && cpu_vector == '0));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .cpu_mask  (cpu_mask),
  .cpu_irq   (cpu_irq),
  .cpu_level (cpu_level),
  .cpu_vector(cpu_vector),
  .line_mode (line_mode),
  .en_mask   (en_mask)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  logic        clk;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  irl_in;
  logic [59:0] periph_irq;
  logic [3:0]  cpu_mask;
  logic        cpu_irq;
  logic [3:0]  cpu_level;
  logic [11:0] cpu_vector;

  int n_chk;
  int n_fail;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irl_in(irl_in), .periph_irq(periph_irq), .cpu_mask(cpu_mask),
    .cpu_irq(cpu_irq), .cpu_level(cpu_level), .cpu_vector(cpu_vector)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [63:0] raw;
    logic [3:0]  mask;
    logic        irq;
    logic [3:0]  lvl;
    logic [11:0] vec;
  } vec_t;

  // Line mode, all enabled, priority of source i = i%8 (+8 for i>=32).
  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{64'h0,                   4'd0,  1'b0, 4'd0,  12'h000},
    '{64'h20,                  4'd0,  1'b1, 4'd5,  12'h820},
    '{64'h202,                 4'd0,  1'b1, 4'd1,  12'h2A0},
    '{64'h202,                 4'd1,  1'b0, 4'd1,  12'h2A0},
    '{64'h100,                 4'd0,  1'b0, 4'd0,  12'h000},
    '{64'h8000_0000_0000_0080, 4'd14, 1'b1, 4'd15, 12'hF60},
    '{64'h8000_0080_0000_0000, 4'd15, 1'b0, 4'd15, 12'hC60},
    '{64'hC,                   4'd2,  1'b1, 4'd3,  12'h360},
    '{64'h0000_0100_0000_0080, 4'd7,  1'b1, 4'd8,  12'hC80}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #2 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic drive(input logic [63:0] raw, input logic [3:0] m);
    @(negedge clk);
    irl_in = raw[3:0]; periph_irq = raw[63:4]; cpu_mask = m;
    @(negedge clk);
    #1;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    irl_in = '0; periph_irq = '0; cpu_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(cpu_irq), 32'h0);
    chk("R1 level", 32'(cpu_level), 32'h0);
    chk("R1 vector", 32'(cpu_vector), 32'h0);
    rd_chk("R1 ctrl", 8'h00, 32'h0);
    rd_chk("R1 enable lo", 8'h70, 32'h0);
    rd_chk("R1 enable hi", 8'h78, 32'h0);
    rd_chk("R1 prio 0", 8'h10, 32'h0);
    rd_chk("R1 prio 7", 8'h48, 32'h0);

    // R2 set/clear enables
    wr(8'h70, 32'h0000_00F0);
    rd_chk("R2 set", 8'h70, 32'h0000_00F0);
    rd_chk("R2 read at disable addr", 8'h80, 32'h0000_00F0);
    wr(8'h80, 32'h0000_0030);
    rd_chk("R2 clear", 8'h70, 32'h0000_00C0);
    wr(8'h70, 32'h0);
    rd_chk("R2 zero write keeps", 8'h70, 32'h0000_00C0);
    wr(8'h78, 32'h8000_0000);
    rd_chk("R2 upper word", 8'h88, 32'h8000_0000);

    // R4 mode bit
    wr(8'h00, 32'h1);
    rd_chk("R4 set", 8'h08, 32'h1);
    wr(8'h08, 32'h1);
    rd_chk("R4 clear", 8'h00, 32'h0);
    wr(8'h00, 32'h2);
    rd_chk("R4 bit0 zero no effect", 8'h00, 32'h0);

    // Full setup: line mode, all enabled, priorities
    wr(8'h00, 32'h1);
    wr(8'h70, 32'hFFFF_FFFF);
    wr(8'h78, 32'hFFFF_FFFF);
    for (int k = 0; k < 8; k++) begin
      logic [31:0] d;
      for (int f = 0; f < 8; f++) d[f*4 +: 4] = 4'(f + ((k >= 4) ? 8 : 0));
      wr(8'(8'h10 + 8 * k), d);
    end
    // R3 readback of packed priorities
    rd_chk("R3 prio reg 0", 8'h10, 32'h7654_3210);
    rd_chk("R3 prio reg 5", 8'h38, 32'hFEDC_BA98);

    // R5 status and request registers
    drive(64'h0000_0100_0000_0020, 4'd0);
    rd_chk("R5 status lo", 8'h50, 32'h0000_0020);
    rd_chk("R5 status hi", 8'h58, 32'h0000_0100);
    rd_chk("R5 request hi", 8'h68, 32'h0000_0100);
    wr(8'h88, 32'h0000_0100);
    rd_chk("R5 request hi masked", 8'h68, 32'h0);
    rd_chk("R5 status hi unmasked", 8'h58, 32'h0000_0100);
    @(negedge clk); #1;
    chk("R2 disabled source loses", 32'(cpu_level), 32'h5);
    wr(8'h78, 32'h0000_0100);

    // Table walk: R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      drive(TBL[v].raw, TBL[v].mask);
      chk($sformatf("R7 level vec%0d", v), 32'(cpu_level), 32'(TBL[v].lvl));
      chk($sformatf("R8 vector vec%0d", v), 32'(cpu_vector), 32'(TBL[v].vec));
      chk($sformatf("R9 irq vec%0d (R6 when level 0)", v), 32'(cpu_irq), 32'(TBL[v].irq));
    end

    // R10 encoded mode
    wr(8'h08, 32'h1);
    drive(64'h0000_0100_0000_0009, 4'd0);
    chk("R10 encoded wins level", 32'(cpu_level), 32'h9);
    chk("R10 encoded vector", 32'(cpu_vector), 32'h240);
    chk("R10 encoded irq", 32'(cpu_irq), 32'h1);
    rd_chk("R10 lines unused in request", 8'h60, 32'h0);
    drive(64'h0000_0100_0000_0008, 4'd0);
    chk("R10 encoded wins tie", 32'(cpu_vector), 32'h240);
    drive(64'h0000_0100_0000_0000, 4'd0);
    chk("R10 zero level gives way", 32'(cpu_vector), 32'hC80);

    // R11 one-cycle latency
    @(negedge clk);
    periph_irq = '0;
    #1 chk("R11 output not yet changed", 32'(cpu_level), 32'h8);
    @(negedge clk); #1;
    chk("R11 output after one edge", 32'(cpu_level), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule